// File: doc/BRIEF.md
# Double-Buffered Operand Staging Unit

This unit sits between a slow memory port and an arithmetic pipeline. Two input ping-pong buffers, A-side and B-side, collect operand words from memory. They hand matched operand pairs to the pipeline. A third ping-pong buffer gathers the pipeline's results and sends them back to memory. Each buffer has two halves of eight words. Memory fills (or drains) one half while the other half serves the pipeline, so memory latency stays hidden behind octet-sized bursts.

When the controller flags a dependency, the result buffer does not write its next octet to memory. That octet is copied word by word into the fill half of the selected operand buffer instead, which saves a round trip through memory. Every stream is a plain valid/ready handshake. Address generation and the arithmetic itself are not part of this block.

Top module: `operand_stager`

## Requirements
- R1: After reset, `op_valid` and `wb_valid` are low, and `mem_a_ready`, `mem_b_ready` and `res_ready` are high.
- R2: Each buffer's fill half takes exactly eight words. Its ready then stays low until the halves swap. A swap only happens once the other half has been fully consumed, and it happens no earlier than the cycle in which the last word is consumed.
- R3: `op_valid` is high only when both operand buffers have unread words in their consume halves. While one of them is empty, no pair is offered, however full the other one is.
- R4: Operand words come out in the order they entered each buffer, across any number of octets. `op_a` and `op_b` are taken from the same position of their respective octets, and a stalled `op_ready` loses or repeats nothing.
- R5: Results leave on `wb_data` in arrival order, in whole octets. A partly filled result half is not drained.
- R6: Once the result fill half holds eight words and the drain half is not empty, `res_ready` is low. No result is lost or duplicated while this backpressure lasts.
- R7: While `fwd_req` is high, a result octet from which no word has been drained yet is not offered to write-back. Once that octet is claimed, all eight of its words go into the operand buffer picked by `fwd_sel` (0 = A-side, 1 = B-side), and none appears on `wb_data`.
- R8: From the cycle a transfer is claimed until its eighth word is written, the memory-fill ready of the target buffer is low. Only one source ever writes a buffer in a given cycle.
- R9: A transfer is claimed only when the target's fill half is empty. Memory fill into a partly filled target continues until that octet completes and swaps, and the transfer then follows it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mem_a_valid | input | 1 | Memory word for A-side buffer valid |
| mem_a_data | input | DW | Memory word for A-side buffer |
| mem_a_ready | output | 1 | A-side fill half can accept a memory word |
| mem_b_valid | input | 1 | Memory word for B-side buffer valid |
| mem_b_data | input | DW | Memory word for B-side buffer |
| mem_b_ready | output | 1 | B-side fill half can accept a memory word |
| op_valid | output | 1 | Operand pair available |
| op_a | output | DW | First operand |
| op_b | output | DW | Second operand |
| op_ready | input | 1 | Pipeline takes the pair |
| res_valid | input | 1 | Result word from pipeline valid |
| res_data | input | DW | Result word |
| res_ready | output | 1 | Result buffer can accept |
| wb_valid | output | 1 | Result word for memory valid |
| wb_data | output | DW | Result word for memory |
| wb_ready | input | 1 | Memory accepts the write-back word |
| fwd_req | input | 1 | Dependency flag: route the next result octet back to an operand buffer |
| fwd_sel | input | 1 | Transfer target, 0 = A-side, 1 = B-side |

## Verification
Two things can compete for the same operand buffer in the same cycle: a memory fill and a result-octet transfer. The bench provokes this by raising `fwd_req` while result octets are waiting. In one case the target is empty, and the bench watches the target's memory ready stay low for all eight transfer cycles. In the other case the target holds a partial memory octet, and the bench checks that memory still completes that octet first. It judges the outcome by the order of the words that later reach `op_a` or `op_b`, and by the absence of those words on write-back.

// File: rtl/stg_pkg.sv
package stg_pkg;
  typedef enum logic {TGT_A = 1'b0, TGT_B = 1'b1} stg_tgt_e;

  // halves exchange roles once the fill side is complete and the
  // consume side is either exhausted or giving up its final word now
  function automatic logic half_swap(input logic fill_full,
                                     input logic cons_empty,
                                     input logic cons_last);
    return fill_full && (cons_empty || cons_last);
  endfunction
endpackage

// File: rtl/stg_pingpong.sv
module stg_pingpong #(
  parameter int DW    = 32,
  parameter int DEPTH = 8,
  localparam int CW   = $clog2(DEPTH + 1),
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  output logic          wr_ready,
  input  logic          rd_en,
  output logic [DW-1:0] rd_data,
  output logic          rd_valid,
  output logic [CW-1:0] fill_cnt,
  output logic [CW-1:0] cons_left,
  output logic          swap
);
  import stg_pkg::*;
  localparam logic [CW-1:0] FULL = CW'(DEPTH);

  logic [DW-1:0] store [2][DEPTH];
  logic          fill_half;
  logic [AW-1:0] rd_ptr;
  logic          wr_fire, rd_fire, rd_last;

  assign wr_ready = (fill_cnt != FULL);
  assign rd_valid = (cons_left != '0);
  assign wr_fire  = wr_en && wr_ready;
  assign rd_fire  = rd_en && rd_valid;
  assign rd_last  = rd_fire && (cons_left == CW'(1));
  assign swap     = half_swap(fill_cnt == FULL, cons_left == '0, rd_last);
  assign rd_data  = store[~fill_half][rd_ptr];

  always_ff @(posedge clk) begin
    if (wr_fire) store[fill_half][fill_cnt[AW-1:0]] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fill_half <= 1'b0;
      fill_cnt  <= '0;
      cons_left <= '0;
      rd_ptr    <= '0;
    end else if (swap) begin
      fill_half <= ~fill_half;
      fill_cnt  <= '0;
      cons_left <= FULL;
      rd_ptr    <= '0;
    end else begin
      if (wr_fire) fill_cnt <= fill_cnt + CW'(1);
      if (rd_fire) begin
        cons_left <= cons_left - CW'(1);
        rd_ptr    <= rd_ptr + AW'(1);
      end
    end
  end
endmodule

// File: rtl/stg_fwd_ctrl.sv
module stg_fwd_ctrl #(
  parameter int DEPTH = 8,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fwd_req,
  input  logic          fwd_sel,
  input  logic [CW-1:0] z_cons_left,
  input  logic [CW-1:0] a_fill_cnt,
  input  logic [CW-1:0] b_fill_cnt,
  output logic          fwd_go,
  output logic          fwd_to_b,
  output logic          fwd_busy,
  output logic          wb_hold
);
  import stg_pkg::*;
  localparam logic [CW-1:0] FULL = CW'(DEPTH);

  stg_tgt_e tgt_q;
  logic     tgt_empty, start, last;

  assign fwd_to_b  = fwd_busy ? (tgt_q == TGT_B) : fwd_sel;
  assign tgt_empty = fwd_to_b ? (b_fill_cnt == '0) : (a_fill_cnt == '0);
  assign start     = fwd_req && !fwd_busy && (z_cons_left == FULL) && tgt_empty;
  assign fwd_go    = start || fwd_busy;
  assign last      = fwd_go && (z_cons_left == CW'(1));
  assign wb_hold   = fwd_busy || (fwd_req && (z_cons_left == FULL));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fwd_busy <= 1'b0;
      tgt_q    <= TGT_A;
    end else if (last) begin
      fwd_busy <= 1'b0;
    end else if (start) begin
      fwd_busy <= 1'b1;
      tgt_q    <= fwd_sel ? TGT_B : TGT_A;
    end
  end
endmodule

// File: rtl/operand_stager.sv
module operand_stager #(
  parameter int DW    = 32,
  parameter int DEPTH = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mem_a_valid,
  input  logic [DW-1:0] mem_a_data,
  output logic          mem_a_ready,
  input  logic          mem_b_valid,
  input  logic [DW-1:0] mem_b_data,
  output logic          mem_b_ready,
  output logic          op_valid,
  output logic [DW-1:0] op_a,
  output logic [DW-1:0] op_b,
  input  logic          op_ready,
  input  logic          res_valid,
  input  logic [DW-1:0] res_data,
  output logic          res_ready,
  output logic          wb_valid,
  output logic [DW-1:0] wb_data,
  input  logic          wb_ready,
  input  logic          fwd_req,
  input  logic          fwd_sel
);
  localparam int CW = $clog2(DEPTH + 1);

  logic          a_wr_en, b_wr_en, a_wr_ready, b_wr_ready;
  logic [DW-1:0] a_wr_data, b_wr_data;
  logic          a_rd_valid, b_rd_valid, z_rd_valid, z_rd_en;
  logic [CW-1:0] a_fcnt, b_fcnt, z_fcnt, a_cleft, b_cleft, z_cleft;
  logic          a_swap, b_swap, z_swap, op_fire;
  logic          fwd_go, fwd_to_b, fwd_busy, wb_hold;
  logic          a_fwd_we, b_fwd_we;

  // transfer writes into the target buffer
  assign a_fwd_we    = fwd_go && !fwd_to_b;
  assign b_fwd_we    = fwd_go &&  fwd_to_b;
  assign mem_a_ready = a_wr_ready && !a_fwd_we;
  assign mem_b_ready = b_wr_ready && !b_fwd_we;
  assign a_wr_en     = a_fwd_we || (mem_a_valid && mem_a_ready);
  assign b_wr_en     = b_fwd_we || (mem_b_valid && mem_b_ready);
  assign a_wr_data   = a_fwd_we ? wb_data : mem_a_data;
  assign b_wr_data   = b_fwd_we ? wb_data : mem_b_data;

  assign op_valid  = a_rd_valid && b_rd_valid;
  assign op_fire   = op_valid && op_ready;
  assign wb_valid  = z_rd_valid && !wb_hold;
  assign z_rd_en   = fwd_go || (wb_valid && wb_ready);

  stg_pingpong #(.DW(DW), .DEPTH(DEPTH)) u_buf_a (
    .clk, .rst_n,
    .wr_en(a_wr_en), .wr_data(a_wr_data), .wr_ready(a_wr_ready),
    .rd_en(op_fire), .rd_data(op_a), .rd_valid(a_rd_valid),
    .fill_cnt(a_fcnt), .cons_left(a_cleft), .swap(a_swap));

  stg_pingpong #(.DW(DW), .DEPTH(DEPTH)) u_buf_b (
    .clk, .rst_n,
    .wr_en(b_wr_en), .wr_data(b_wr_data), .wr_ready(b_wr_ready),
    .rd_en(op_fire), .rd_data(op_b), .rd_valid(b_rd_valid),
    .fill_cnt(b_fcnt), .cons_left(b_cleft), .swap(b_swap));

  stg_pingpong #(.DW(DW), .DEPTH(DEPTH)) u_buf_z (
    .clk, .rst_n,
    .wr_en(res_valid), .wr_data(res_data), .wr_ready(res_ready),
    .rd_en(z_rd_en), .rd_data(wb_data), .rd_valid(z_rd_valid),
    .fill_cnt(z_fcnt), .cons_left(z_cleft), .swap(z_swap));

  stg_fwd_ctrl #(.DEPTH(DEPTH)) u_fwd (
    .clk, .rst_n,
    .fwd_req, .fwd_sel,
    .z_cons_left(z_cleft), .a_fill_cnt(a_fcnt), .b_fill_cnt(b_fcnt),
    .fwd_go, .fwd_to_b, .fwd_busy, .wb_hold);
endmodule

// File: rtl/stg_checker.sv
module stg_checker #(
  parameter int DEPTH = 8,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          op_valid,
  input logic          wb_valid,
  input logic          res_ready,
  input logic          mem_a_valid,
  input logic          mem_a_ready,
  input logic          mem_b_valid,
  input logic          mem_b_ready,
  input logic          a_fwd_we,
  input logic          b_fwd_we,
  input logic          fwd_busy,
  input logic          a_swap,
  input logic [CW-1:0] a_fcnt,
  input logic [CW-1:0] z_fcnt,
  input logic [CW-1:0] a_cleft,
  input logic [CW-1:0] b_cleft
);
  a_r2_fill_bound: assert property (@(posedge clk) disable iff (!rst_n)
    a_fcnt <= CW'(DEPTH));

  a_r3_pair_needs_both: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid |-> (a_cleft != '0) && (b_cleft != '0));

  a_r4_swap_loads_octet: assert property (@(posedge clk) disable iff (!rst_n)
    a_swap |=> (a_cleft == CW'(DEPTH)));

  a_r6_backpressure_full: assert property (@(posedge clk) disable iff (!rst_n)
    !res_ready |-> (z_fcnt == CW'(DEPTH)));

  a_r7_fwd_blocks_wb: assert property (@(posedge clk) disable iff (!rst_n)
    fwd_busy |-> !wb_valid);

  a_r8_single_writer_a: assert property (@(posedge clk) disable iff (!rst_n)
    !(a_fwd_we && mem_a_valid && mem_a_ready));

  a_r8_single_writer_b: assert property (@(posedge clk) disable iff (!rst_n)
    !(b_fwd_we && mem_b_valid && mem_b_ready));
endmodule

bind operand_stager stg_checker #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .wb_valid(wb_valid),
  .res_ready(res_ready), .mem_a_valid(mem_a_valid), .mem_a_ready(mem_a_ready),
  .mem_b_valid(mem_b_valid), .mem_b_ready(mem_b_ready),
  .a_fwd_we(a_fwd_we), .b_fwd_we(b_fwd_we), .fwd_busy(fwd_busy),
  .a_swap(a_swap), .a_fcnt(a_fcnt), .z_fcnt(z_fcnt),
  .a_cleft(a_cleft), .b_cleft(b_cleft));

// File: tb/operand_stager_test.sv
`timescale 1ns/1ps
module operand_stager_test;
  localparam int DW = 32;
  localparam int DEPTH = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mem_a_valid = 0, mem_b_valid = 0, op_ready = 0, res_valid = 0;
  logic wb_ready = 0, fwd_req = 0, fwd_sel = 0;
  logic [DW-1:0] mem_a_data = '0, mem_b_data = '0, res_data = '0;
  logic mem_a_ready, mem_b_ready, op_valid, res_ready, wb_valid;
  logic [DW-1:0] op_a, op_b, wb_data;

  int checks = 0, failures = 0;
  logic [DW-1:0] exp_a[$], exp_b[$], exp_wb[$], held[$];

  always #4 clk = ~clk;

  operand_stager #(.DW(DW), .DEPTH(DEPTH)) uut (.*);

  task automatic check(input bit ok, input string req, input logic [DW-1:0] act,
                       input logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // monitor: operand pairs (R3, R4) and write-back stream (R5, R7)
  always @(negedge clk) begin
    if (rst_n && op_valid && op_ready) begin
      if (exp_a.size() == 0 || exp_b.size() == 0)
        check(1'b0, "R3 unexpected pair", op_a, '0);
      else begin
        logic [DW-1:0] ea, eb;
        ea = exp_a.pop_front();
        eb = exp_b.pop_front();
        check(op_a == ea, "R4 op_a order", op_a, ea);
        check(op_b == eb, "R4 op_b order", op_b, eb);
      end
    end
    if (rst_n && wb_valid && wb_ready) begin
      if (exp_wb.size() == 0)
        check(1'b0, "R7 unexpected write-back", wb_data, '0);
      else begin
        logic [DW-1:0] ew;
        ew = exp_wb.pop_front();
        check(wb_data == ew, "R5 write-back order", wb_data, ew);
      end
    end
  end

  task automatic push_a(input logic [DW-1:0] d);
    mem_a_valid = 1; mem_a_data = d;
    @(negedge clk);
    while (!mem_a_ready) @(negedge clk);
    exp_a.push_back(d);
    @(posedge clk); #1 mem_a_valid = 0;
  endtask

  task automatic push_b(input logic [DW-1:0] d);
    mem_b_valid = 1; mem_b_data = d;
    @(negedge clk);
    while (!mem_b_ready) @(negedge clk);
    exp_b.push_back(d);
    @(posedge clk); #1 mem_b_valid = 0;
  endtask

  // dest: 0 write-back, 1 A-side, 2 B-side, 3 held for later
  task automatic send_res(input logic [DW-1:0] d, input int dest);
    res_valid = 1; res_data = d;
    @(negedge clk);
    while (!res_ready) @(negedge clk);
    case (dest)
      0: exp_wb.push_back(d);
      1: exp_a.push_back(d);
      2: exp_b.push_back(d);
      default: held.push_back(d);
    endcase
    @(posedge clk); #1 res_valid = 0;
  endtask

  task automatic drain(input string req);
    int n = 0;
    while ((exp_a.size() != 0 || exp_b.size() != 0 || exp_wb.size() != 0) && n < 2000) begin
      @(posedge clk); #1; n++;
    end
    check(n < 2000, req, DW'(exp_a.size() + exp_b.size() + exp_wb.size()), '0);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin @(posedge clk); #1; end
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    idle(3);
    @(negedge clk);
    // R1: reset state
    check(!op_valid, "R1 op_valid", DW'(op_valid), 0);
    check(!wb_valid, "R1 wb_valid", DW'(wb_valid), 0);
    check(mem_a_ready && mem_b_ready, "R1 mem ready", DW'({mem_a_ready, mem_b_ready}), 3);
    check(res_ready, "R1 res_ready", DW'(res_ready), 1);
    @(posedge clk); #1 rst_n = 1;

    // R3: A-side full, B-side empty -> no pair
    op_ready = 1;
    for (int i = 0; i < DEPTH; i++) push_a(32'hA000 + i);
    idle(3); @(negedge clk);
    check(!op_valid, "R3 one side empty", DW'(op_valid), 0);
    @(posedge clk); #1;
    // R2: second octet fills, consume half untouched -> ready low
    for (int i = 0; i < DEPTH; i++) push_a(32'hA100 + i);
    @(negedge clk);
    check(!mem_a_ready, "R2 fill half full", DW'(mem_a_ready), 0);
    check(!op_valid, "R3 still one side", DW'(op_valid), 0);
    @(posedge clk); #1;
    for (int i = 0; i < 2 * DEPTH; i++) push_b(32'hB000 + i);
    drain("R4 pairs drained");

    // R4: several octets with a stalling pipeline
    fork
      for (int i = 0; i < 3 * DEPTH; i++) push_a(32'hA200 + i);
      for (int i = 0; i < 3 * DEPTH; i++) push_b(32'hB200 + i);
      for (int i = 0; i < 120; i++) begin @(posedge clk); #1 op_ready = (i % 3) != 1; end
    join
    op_ready = 1;
    drain("R4 stalled stream");

    // R5: results drain in order
    wb_ready = 1;
    for (int i = 0; i < 2 * DEPTH; i++) send_res(32'hC000 + i, 0);
    drain("R5 write-back drained");

    // R6: backpressure when both result halves full
    wb_ready = 0;
    for (int i = 0; i < 2 * DEPTH; i++) send_res(32'hC100 + i, 0);
    idle(2); @(negedge clk);
    check(!res_ready, "R6 res_ready low", DW'(res_ready), 0);
    check(wb_valid, "R6 wb pending", DW'(wb_valid), 1);
    @(posedge clk); #1 wb_ready = 1;
    drain("R6 no result lost");

    // R7, R8: transfer into A-side
    wb_ready = 0; op_ready = 0;
    for (int i = 0; i < DEPTH; i++) send_res(32'hD000 + i, 1);
    idle(2);
    fwd_req = 1; fwd_sel = 0; wb_ready = 1;
    for (int i = 0; i < DEPTH; i++) begin
      @(negedge clk);
      check(!mem_a_ready, "R8 A fill held off", DW'(mem_a_ready), 0);
      check(!wb_valid, "R7 no write-back", DW'(wb_valid), 0);
    end
    @(posedge clk); #1 fwd_req = 0;
    for (int i = 0; i < DEPTH; i++) push_b(32'hB300 + i);
    op_ready = 1;
    drain("R7 A-side transfer");

    // R7, R8: transfer into B-side
    wb_ready = 0; op_ready = 0;
    for (int i = 0; i < DEPTH; i++) send_res(32'hD100 + i, 2);
    idle(2);
    fwd_req = 1; fwd_sel = 1; wb_ready = 1;
    for (int i = 0; i < DEPTH; i++) begin
      @(negedge clk);
      check(!mem_b_ready, "R8 B fill held off", DW'(mem_b_ready), 0);
      check(!wb_valid, "R7 no write-back B", DW'(wb_valid), 0);
    end
    @(posedge clk); #1 fwd_req = 0;
    for (int i = 0; i < DEPTH; i++) push_a(32'hA400 + i);
    op_ready = 1;
    drain("R7 B-side transfer");

    // R9: target partly filled by memory, transfer waits
    op_ready = 0; wb_ready = 0;
    for (int i = 0; i < 3; i++) push_a(32'hA500 + i);
    for (int i = 0; i < DEPTH; i++) send_res(32'hD200 + i, 3);
    idle(2);
    fwd_req = 1; fwd_sel = 0; wb_ready = 1;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check(mem_a_ready, "R9 memory keeps target", DW'(mem_a_ready), 1);
      check(!wb_valid, "R9 octet reserved", DW'(wb_valid), 0);
    end
    @(posedge clk); #1;
    for (int i = 3; i < DEPTH; i++) push_a(32'hA500 + i);
    while (held.size() != 0) exp_a.push_back(held.pop_front());
    idle(DEPTH + 6);
    fwd_req = 0;
    for (int i = 0; i < 2 * DEPTH; i++) push_b(32'hB600 + i);
    op_ready = 1;
    drain("R9 transfer after memory octet");

    idle(4);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule